// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Monitor and Power Gating

This block turns the output edges of a reference divider and a main divider into pump commands for two charge pumps, a normal one and a fast one. When the reference edge leads, the block asks the pumps to source current (up). When the main edge leads, it asks them to sink current (down). The pulse lasts as long as the gap between the two edges, measured in cycles of a fast sampling clock. A fast-mode request widens the loop while it is on. A two-bit code selects the current multipliers for both pumps. A lock monitor reports whether the last phase error was inside a tolerance window.

The block also decides whether the synthesizer is on. It combines a pin request with a programmed bit, and a polarity input selects whether both are active high or both active low. Changes to the fast request and to power-down take effect only at pulse boundaries, so no pump pulse is ever cut short. The divider outputs and all control inputs are level signals synchronous to `clk`. The block has no stream interface, so it carries no valid/ready handshake.

Top module: `pfd_lock_power`

## Requirements
- R1: After reset, all four pump commands are low, `lock_flag` is high and `synth_on` is low.
- R2: A rising edge on `ref_div_in` that leads the rising edge on `main_div_in` by k cycles (k ≥ 1) gives `up_norm` high for k+1 cycles and `dn_norm` high for 1 cycle. The last cycle is an overlap, after which both clear together. A level held high counts as one edge only.
- R3: When the main edge leads by k cycles, the roles swap: `dn_norm` is high for k+1 cycles and `up_norm` is high for 1 cycle.
- R4: Coincident edges give exactly one cycle with `up_norm` and `dn_norm` both high.
- R5: `fast_req` is taken only while both pumps are idle. Within a pulse, `up_fast` and `dn_fast` either mirror `up_norm` and `dn_norm` for the whole pulse or stay low for the whole pulse.
- R6: `cur_code` selects `norm_mult`/`fast_mult` as follows: 00 gives 2/8, 01 gives 2/16, 10 gives 1/12, 11 gives 1/16.
- R7: The request is on only when `pon_pin` and `pon_bit` both equal `pol_sel`. `pol_sel` = 1 means active high and 0 means active low. With the pumps idle, `synth_on` follows the request one clock later.
- R8: When the request drops during a pulse, that pulse runs to its natural end before `synth_on` falls. While `synth_on` is low, divider edges produce no pump activity.
- R9: With `lock_det_en` high and the block on, `lock_flag` is updated at the end of each pulse. It goes high if the non-overlap width was at most LOCK_TOL_CYC cycles and low otherwise. With detection disabled, or while the block is off, `lock_flag` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div_in | input | 1 | Reference divider output |
| main_div_in | input | 1 | Main divider output |
| fast_req | input | 1 | Fast-pump enable request |
| pol_sel | input | 1 | Active level of the power requests |
| pon_pin | input | 1 | Hardware power request |
| pon_bit | input | 1 | Programmed power request |
| lock_det_en | input | 1 | Lock monitor enable |
| cur_code | input | 2 | Pump current selection code |
| up_norm | output | 1 | Normal pump source command |
| dn_norm | output | 1 | Normal pump sink command |
| up_fast | output | 1 | Fast pump source command |
| dn_fast | output | 1 | Fast pump sink command |
| norm_mult | output | 2 | Normal pump current multiple |
| fast_mult | output | 5 | Fast pump current multiple |
| lock_flag | output | 1 | High when in lock or detection is off |
| synth_on | output | 1 | Synthesizer running state |

## Verification
The assertions check the following on every cycle:
- the pumps are silent while the block is off;
- an overlap always clears on the next cycle;
- the fast commands are never active without the matching normal command and never change inside a pulse;
- `lock_flag` stays high when detection is disabled.

Only the bench scenarios can show the following:
- the exact pulse widths across a sweep of leads and lags;
- the tolerance boundary of the lock decision;
- the polarity truth table;
- that a pulse cut by power-down still reaches full length.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int NMULT_W = 2;
  localparam int FMULT_W = 5;

  typedef struct packed {
    logic [NMULT_W-1:0] norm;
    logic [FMULT_W-1:0] fast;
  } pump_gain_t;

  function automatic pump_gain_t gain_of(input logic [1:0] code);
    pump_gain_t g;
    g.norm = code[1] ? NMULT_W'(1) : NMULT_W'(2);
    case (code)
      2'b00:   g.fast = FMULT_W'(8);
      2'b10:   g.fast = FMULT_W'(12);
      default: g.fast = FMULT_W'(16);
    endcase
    return g;
  endfunction
endpackage

// File: rtl/pfd_power_ctl.sv
module pfd_power_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pol_sel,
  input  logic pon_pin,
  input  logic pon_bit,
  input  logic idle,
  output logic req,
  output logic run
);
  assign req = pol_sel ? (pon_pin & pon_bit) : (~pon_pin & ~pon_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else if (!run) run <= req;
    else if (!req && idle) run <= 1'b0;
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic allow_start,
  input  logic ref_in,
  input  logic main_in,
  input  logic fast_req,
  output logic up,
  output logic dn,
  output logic up_f,
  output logic dn_f,
  output logic idle
);
  logic ref_q, main_q, fast_q;
  logic ref_edge, main_edge, both;

  assign ref_edge  = ref_in & ~ref_q & run;
  assign main_edge = main_in & ~main_q & run;
  assign both      = up & dn;
  assign idle      = ~up & ~dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      main_q <= 1'b0;
      up     <= 1'b0;
      dn     <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      ref_q  <= ref_in;
      main_q <= main_in;
      if (both) begin
        up <= 1'b0;
        dn <= 1'b0;
      end else begin
        up <= up | (ref_edge & (allow_start | dn));
        dn <= dn | (main_edge & (allow_start | up));
      end
      if (idle) fast_q <= fast_req;
    end
  end

  assign up_f = up & fast_q;
  assign dn_f = dn & fast_q;
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int LOCK_TOL_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  input  logic run,
  input  logic en,
  output logic lock_flag
);
  localparam int CNT_MAX = LOCK_TOL_CYC + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] err_cnt;
  logic             lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
      lock_q  <= 1'b1;
    end else if (!run) begin
      err_cnt <= '0;
      lock_q  <= 1'b1;
    end else if (up && dn) begin
      lock_q  <= (err_cnt <= CNT_W'(LOCK_TOL_CYC));
      err_cnt <= '0;
    end else if ((up ^ dn) && err_cnt != CNT_W'(CNT_MAX)) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end

  assign lock_flag = ~run | ~en | lock_q;
endmodule

// File: rtl/pfd_lock_power.sv
module pfd_lock_power #(
  parameter int LOCK_TOL_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_div_in,
  input  logic       main_div_in,
  input  logic       fast_req,
  input  logic       pol_sel,
  input  logic       pon_pin,
  input  logic       pon_bit,
  input  logic       lock_det_en,
  input  logic [1:0] cur_code,
  output logic       up_norm,
  output logic       dn_norm,
  output logic       up_fast,
  output logic       dn_fast,
  output logic [1:0] norm_mult,
  output logic [4:0] fast_mult,
  output logic       lock_flag,
  output logic       synth_on
);
  import pfd_pkg::*;

  logic req, run, idle;
  pump_gain_t gain;

  pfd_power_ctl u_pwr (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .pon_pin(pon_pin),
    .pon_bit(pon_bit), .idle(idle), .req(req), .run(run)
  );

  pfd_core u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .allow_start(req),
    .ref_in(ref_div_in), .main_in(main_div_in), .fast_req(fast_req),
    .up(up_norm), .dn(dn_norm), .up_f(up_fast), .dn_f(dn_fast), .idle(idle)
  );

  pfd_lock_mon #(.LOCK_TOL_CYC(LOCK_TOL_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .up(up_norm), .dn(dn_norm), .run(run),
    .en(lock_det_en), .lock_flag(lock_flag)
  );

  assign gain      = gain_of(cur_code);
  assign norm_mult = gain.norm;
  assign fast_mult = gain.fast;
  assign synth_on  = run;
endmodule

// File: rtl/pfd_lock_power_chk.sv
module pfd_lock_power_chk (
  input logic clk,
  input logic rst_n,
  input logic up_norm,
  input logic dn_norm,
  input logic up_fast,
  input logic dn_fast,
  input logic lock_det_en,
  input logic lock_flag,
  input logic synth_on
);
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !synth_on |-> (!up_norm && !dn_norm)); // R8
  AST_OVERLAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_norm && dn_norm) |=> (!up_norm && !dn_norm)); // R2
  AST_FAST_UP_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    up_fast |-> up_norm); // R5
  AST_FAST_DN_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_fast |-> dn_norm); // R5
  AST_FAST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_norm && $past(up_norm)) |-> (up_fast == $past(up_fast))); // R5
  AST_LOCK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_det_en |-> lock_flag); // R9
endmodule

bind pfd_lock_power pfd_lock_power_chk u_chk (
  .clk(clk), .rst_n(rst_n), .up_norm(up_norm), .dn_norm(dn_norm),
  .up_fast(up_fast), .dn_fast(dn_fast), .lock_det_en(lock_det_en),
  .lock_flag(lock_flag), .synth_on(synth_on)
);

// File: tb/pfd_lock_power_bench.sv
`timescale 1ns/1ps
module pfd_lock_power_bench;
  localparam int TOL = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_div_in = 0, main_div_in = 0, fast_req = 0;
  logic pol_sel = 1, pon_pin = 0, pon_bit = 1, lock_det_en = 1;
  logic [1:0] cur_code = 0;
  logic up_norm, dn_norm, up_fast, dn_fast, lock_flag, synth_on;
  logic [1:0] norm_mult;
  logic [4:0] fast_mult;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pfd_lock_power #(.LOCK_TOL_CYC(TOL)) u_pfd_lock_power (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pair(input int k, input int fast_at, input int off_at, input int len,
                      output int nu, output int nd, output int nfu, output int nfd);
    int ta, tm;
    ta = (k >= 0) ? 0 : -k;
    tm = (k >= 0) ? k : 0;
    nu = 0; nd = 0; nfu = 0; nfd = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      nu += int'(up_norm); nd += int'(dn_norm);
      nfu += int'(up_fast); nfd += int'(dn_fast);
      ref_div_in  = (i == ta);
      main_div_in = (i == tm);
      if (i == fast_at) fast_req = 1;
      if (i == off_at) pon_pin = ~pol_sel;
    end
  endtask

  initial begin
    int nu, nd, nfu, nfd, eu, ed;
    bit exp_on;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(!up_norm && !dn_norm && !up_fast && !dn_fast, "R1 pumps", up_norm + dn_norm, 0);
    chk(lock_flag == 1, "R1 lock", lock_flag, 1);
    chk(synth_on == 0, "R1 on", synth_on, 0);
    rst_n = 1;
    // R7 polarity sweep
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++) begin
          @(negedge clk);
          pol_sel = p[0]; pon_pin = a[0]; pon_bit = b[0];
          repeat (3) @(negedge clk);
          exp_on = (a == p) && (b == p);
          chk(synth_on == exp_on, "R7 power request", synth_on, exp_on);
        end
    // pol_sel=1, pon_pin=1, pon_bit=1: on
    // R2 R3 R4 R9 sweep of lead and lag
    for (int k = -6; k <= 6; k++) begin
      pair(k, -1, -1, (k < 0 ? -k : k) + 8, nu, nd, nfu, nfd);
      eu = (k >= 0) ? k + 1 : 1;
      ed = (k <= 0) ? 1 - k : 1;
      if (k > 0) chk(nu == eu && nd == ed, "R2 ref leads", nu * 100 + nd, eu * 100 + ed);
      else if (k < 0) chk(nu == eu && nd == ed, "R3 main leads", nu * 100 + nd, eu * 100 + ed);
      else chk(nu == 1 && nd == 1, "R4 coincident", nu * 100 + nd, 101);
      chk(lock_flag == ((k < 0 ? -k : k) <= TOL), "R9 lock window", lock_flag,
          int'((k < 0 ? -k : k) <= TOL));
    end
    // R9 detection disabled after an out-of-lock pulse
    pair(6, -1, -1, 14, nu, nd, nfu, nfd);
    chk(lock_flag == 0, "R9 out of lock", lock_flag, 0);
    lock_det_en = 0;
    @(negedge clk);
    chk(lock_flag == 1, "R9 disabled", lock_flag, 1);
    lock_det_en = 1;
    // R5 fast request mid-pulse is deferred
    pair(4, 2, -1, 12, nu, nd, nfu, nfd);
    chk(nfu == 0 && nfd == 0, "R5 deferred", nfu + nfd, 0);
    pair(-3, -1, -1, 11, nu, nd, nfu, nfd);
    chk(nfu == nu && nfd == nd && nd == 4, "R5 mirror", nfu * 100 + nfd, 104);
    fast_req = 0;
    // R6 codes
    for (int c = 0; c < 4; c++) begin
      cur_code = c[1:0];
      #1;
      eu = (c < 2) ? 2 : 1;
      ed = (c == 0) ? 8 : (c == 2) ? 12 : 16;
      chk(norm_mult == eu && fast_mult == ed, "R6 gain code",
          norm_mult * 100 + fast_mult, eu * 100 + ed);
    end
    // R8 power drop during pulse
    pair(5, -1, 2, 14, nu, nd, nfu, nfd);
    chk(nu == 6 && nd == 1, "R8 drained pulse", nu * 100 + nd, 601);
    chk(synth_on == 0, "R8 off after drain", synth_on, 0);
    pair(2, -1, -1, 10, nu, nd, nfu, nfd);
    chk(nu == 0 && nd == 0, "R8 edges ignored", nu + nd, 0);
    chk(lock_flag == 1, "R9 off forces lock", lock_flag, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule